// File: doc/BRIEF.md
# Baud Rate Tick Generator with Selectable Prescaler

This block turns a free-running reference clock into a clock-enable pulse at sixteen times the serial bit rate. A serial transmitter and receiver use the pulse to time their oversampling. The rate is set by a 16-bit divisor, which software loads one byte at a time through two separate byte write strobes. A mode input places an extra divide-by-four stage ahead of the divisor. The same divisor value can therefore give two bit rates that differ by a factor of four. For example, with a 14.7456 MHz reference and a divisor of 1, the bit rate is 921.6k with the prescaler off and 230.4k with it on.

The output is a one-cycle enable in the reference clock domain, not a derived clock. Writing either divisor byte restarts both counting stages, so the next pulse is timed entirely by the newly written value. A divisor of zero is treated as 65536 and does not stall the generator.

Top module: `baud_tick_gen`

## Requirements
- R1: The divisor N is {high byte, low byte}. A write strobe on the low-byte port loads bits 7:0, and a write strobe on the high-byte port loads bits 15:8. The byte that is not written keeps its value.
- R2: With the prescale input at 0 and no writes, the tick repeats every N reference cycles.
- R3: With the prescale input at 1 and no writes, the tick repeats every 4*N reference cycles.
- R4: A stored divisor of 0x0000 behaves as N = 65536.
- R5: When N*P is greater than 1, the tick is high for exactly one reference cycle. Here P is 1 with the prescale input at 0 and 4 with it at 1.
- R6: A write to either divisor byte at clock edge W clears both counting stages and forces the tick low. The first following tick is high right after edge W + N*P, where N is the updated divisor.
- R7: While the synchronous reset is high, the tick stays low. Reset sets the divisor to 0x0001 and clears both stages. The first tick after release is high right after the N*P-th edge with reset low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| div_lo_we | input | 1 | Write strobe for the low divisor byte |
| div_hi_we | input | 1 | Write strobe for the high divisor byte |
| wr_data | input | 8 | Byte written by either strobe |
| prescale_en | input | 1 | 1 selects the extra divide-by-four stage |
| tick16_o | output | 1 | One-cycle enable at sixteen times the bit rate |

## Verification
The hardest case to reach from the ports is the zero divisor. It gives a full 65536-cycle interval, and that interval only appears once both bytes hold zero at the same time. The stimulus writes the high byte to zero and then the low byte to zero. It measures from the second write, so the restart on that write defines the start of the window exactly. The combined prescale and large-divisor case takes 9216 cycles. It is reached the same way: the prescale input is set first, and then a byte write restarts the counters, giving a clean boundary.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int DIV_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = DIV_W / BYTE_W;
    localparam int CNT_W     = DIV_W + 1;

    typedef logic [DIV_W-1:0]  div_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        PRE_BYPASS = 1'b0,
        PRE_SLOW   = 1'b1
    } pre_mode_e;

    typedef struct packed {
        logic [NUM_BYTES-1:0] lane_we;
        byte_t                data;
    } div_wr_t;

    // Zero divisor means full range (2**DIV_W); result is terminal count.
    function automatic cnt_t div_last(input div_t d);
        cnt_t full;
        full = cnt_t'(1) << DIV_W;
        if (d == '0)
            return full - cnt_t'(1);
        return cnt_t'(d) - cnt_t'(1);
    endfunction

endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs
    import baud_pkg::*;
#(
    parameter div_t RST_DIV = div_t'(1)
) (
    input  logic    clk,
    input  logic    rst,
    input  div_wr_t wr_i,
    output div_t    div_o,
    output logic    load_o
);

    div_t div_q;

    generate
        for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst)
                    div_q[g*BYTE_W +: BYTE_W] <= RST_DIV[g*BYTE_W +: BYTE_W];
                else if (wr_i.lane_we[g])
                    div_q[g*BYTE_W +: BYTE_W] <= wr_i.data;
            end

            // R1
            lane_load_chk: assert property (@(posedge clk) disable iff (rst)
                wr_i.lane_we[g] |=> div_o[g*BYTE_W +: BYTE_W] == $past(wr_i.data));
        end
    endgenerate

    assign div_o  = div_q;
    assign load_o = |wr_i.lane_we;

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
#(
    parameter int RATIO = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr_i,
    input  pre_mode_e mode_i,
    output logic      step_o
);

    generate
        if (RATIO <= 1) begin : g_none
            assign step_o = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(RATIO);
            localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
            logic [PW-1:0] pcnt_q;

            always_ff @(posedge clk) begin
                if (rst || clr_i)
                    pcnt_q <= '0;
                else if (pcnt_q == LAST)
                    pcnt_q <= '0;
                else
                    pcnt_q <= pcnt_q + PW'(1);
            end

            assign step_o = (mode_i == PRE_BYPASS) || (pcnt_q == LAST);

            // R3
            pre_gap_chk: assert property (@(posedge clk) disable iff (rst)
                (step_o && mode_i == PRE_SLOW) |=> (!step_o || mode_i == PRE_BYPASS));
        end
    endgenerate

endmodule

// File: rtl/baud_divcnt.sv
module baud_divcnt
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic step_i,
    input  div_t div_i,
    output logic tick_o
);

    cnt_t cnt_q;
    cnt_t last;
    logic tick_q;

    assign last = div_last(div_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (step_i) begin
            if (cnt_q == last) begin
                cnt_q  <= '0;
                tick_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + cnt_t'(1);
                tick_q <= 1'b0;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last);

    // R5
    tick_width_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_o && last != '0) |=> !tick_o);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int   PRE_RATIO = 4,
    parameter div_t RST_DIV   = div_t'(1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        div_lo_we,
    input  logic        div_hi_we,
    input  logic [7:0]  wr_data,
    input  logic        prescale_en,
    output logic        tick16_o
);

    div_wr_t   wr;
    div_t      div_val;
    logic      load;
    logic      step;
    pre_mode_e mode;

    assign wr.lane_we = {div_hi_we, div_lo_we};
    assign wr.data    = wr_data;
    assign mode       = prescale_en ? PRE_SLOW : PRE_BYPASS;

    baud_div_regs #(.RST_DIV(RST_DIV)) i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (wr),
        .div_o  (div_val),
        .load_o (load)
    );

    baud_prescaler #(.RATIO(PRE_RATIO)) i_pre (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (load),
        .mode_i (mode),
        .step_o (step)
    );

    baud_divcnt i_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (load),
        .step_i (step),
        .div_i  (div_val),
        .tick_o (tick16_o)
    );

    // R7
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> !tick16_o);

    // R6
    load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> !tick16_o);

endmodule

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       div_lo_we = 1'b0;
    logic       div_hi_we = 1'b0;
    logic [7:0] wr_data = '0;
    logic       prescale_en = 1'b0;
    logic       tick16_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    baud_tick_gen i_baud_tick_gen (
        .clk         (clk),
        .rst         (rst),
        .div_lo_we   (div_lo_we),
        .div_hi_we   (div_hi_we),
        .wr_data     (wr_data),
        .prescale_en (prescale_en),
        .tick16_o    (tick16_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_byte(input bit hi, input logic [7:0] v);
        @(negedge clk);
        div_lo_we = !hi;
        div_hi_we = hi;
        wr_data   = v;
        @(negedge clk);
        div_lo_we = 1'b0;
        div_hi_we = 1'b0;
    endtask

    // Count negedges until tick seen; returns -1 past limit.
    task automatic cycles_to_tick(input int limit, output int k);
        k = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (tick16_o) begin
                k = i;
                return;
            end
        end
        k = -1;
    endtask

    task automatic period(input int limit, output int k);
        int tmp;
        if (!tick16_o) cycles_to_tick(limit, tmp);
        cycles_to_tick(limit, k);
    endtask

    task automatic t_reset;
        bit quiet = 1;
        int k;
        rst = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (tick16_o) quiet = 0;
        end
        check(quiet, "R7", "tick during reset", tick16_o, 0);
        rst = 1'b0;
        cycles_to_tick(4, k);
        check(k == 1, "R7", "first tick after release, default divisor", k, 1);
        period(4, k);
        check(k == 1, "R2", "period with divisor 1", k, 1);
    endtask

    task automatic t_reload_12;
        int k;
        prescale_en = 1'b0;
        wr_byte(0, 8'd12);
        cycles_to_tick(100, k);
        check(k == 12, "R6", "first tick after low write 12", k, 12);
        @(negedge clk);
        check(tick16_o == 0, "R5", "tick width", tick16_o, 0);
        period(100, k);
        check(k == 12, "R2", "period divisor 12", k, 12);
    endtask

    task automatic t_prescale;
        int k;
        prescale_en = 1'b1;
        wr_byte(0, 8'd12);
        cycles_to_tick(200, k);
        check(k == 48, "R6", "first tick, prescaled divisor 12", k, 48);
        period(200, k);
        check(k == 48, "R3", "period prescaled divisor 12", k, 48);
        wr_byte(0, 8'd1);
        cycles_to_tick(20, k);
        check(k == 4, "R3", "first tick prescaled divisor 1", k, 4);
        @(negedge clk);
        check(tick16_o == 0, "R5", "tick width prescaled divisor 1", tick16_o, 0);
        period(20, k);
        check(k == 4, "R3", "period prescaled divisor 1", k, 4);
    endtask

    task automatic t_high_byte;
        int k;
        prescale_en = 1'b0;
        wr_byte(0, 8'h00);
        wr_byte(1, 8'h09);
        cycles_to_tick(3000, k);
        check(k == 2304, "R1", "first tick after high write 0x09", k, 2304);
        period(3000, k);
        check(k == 2304, "R2", "period divisor 0x0900", k, 2304);
        prescale_en = 1'b1;
        wr_byte(1, 8'h09);
        cycles_to_tick(10000, k);
        check(k == 9216, "R3", "first tick prescaled 0x0900", k, 9216);
    endtask

    task automatic t_split;
        int k;
        prescale_en = 1'b0;
        wr_byte(0, 8'h02);
        wr_byte(1, 8'h01);
        cycles_to_tick(400, k);
        check(k == 258, "R1", "divisor 0x0102 from two bytes", k, 258);
        wr_byte(0, 8'h03);
        cycles_to_tick(400, k);
        check(k == 259, "R1", "low write keeps high byte", k, 259);
    endtask

    task automatic t_zero;
        int k;
        prescale_en = 1'b0;
        wr_byte(1, 8'h00);
        wr_byte(0, 8'h00);
        cycles_to_tick(70000, k);
        check(k == 65536, "R4", "zero divisor interval", k, 65536);
    endtask

    task automatic t_reset_mid;
        int k;
        bit quiet = 1;
        prescale_en = 1'b0;
        wr_byte(0, 8'd5);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (tick16_o) quiet = 0;
        end
        check(quiet, "R7", "no tick while reset held mid-run", tick16_o, 0);
        prescale_en = 1'b1;
        rst = 1'b0;
        cycles_to_tick(20, k);
        check(k == 4, "R7", "first tick after release, prescaled default", k, 4);
    endtask

    initial begin
        t_reset();
        t_reload_12();
        t_prescale();
        t_high_byte();
        t_split();
        t_zero();
        t_reset_mid();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait (cyc >= 180000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule